// File: doc/BRIEF.md
# UART Receive Queue with Per-Byte Error Status

This block buffers bytes coming out of a UART receiver. Each stored entry keeps its eight data bits together with four status flags: parity error, framing error, break and overrun. As a result, software or a DMA engine that drains the queue always sees the error condition beside the byte it belongs to. The receiver hands over a fully assembled byte, the parity check result and the sampled level of the first stop bit, all qualified by a one-cycle valid strobe. The block decides by itself whether the frame is a framing error or a break.

The oldest entry is shown combinationally on the read port. A one-cycle pop strobe removes it. A registered fill count from 0 to the depth is provided for flow-control logic, for example to drive a request-to-send threshold. A break frame is stored as two zero bytes. When the queue cannot take what arrives, the excess is discarded and the most recently stored entry is marked with the overrun flag.

Top module: `rxq_status_fifo`

## Requirements
- R1: After reset the fill count is 0 and `head_valid` is low.
- R2: An ordinary received byte is stored in arrival order with its parity-error flag. The read port shows the oldest entry's data and flags without waiting for a clock, and a pop while non-empty removes that entry.
- R3: A frame whose first stop bit is sampled 0 is stored with the framing flag set.
- R4: A frame with stop bit 0 and all eight data bits 0 is a break. It stores two entries with data 0x00, and each of them carries the break and framing flags plus the received parity flag.
- R5: When the queue holds DEPTH (16) entries and a byte arrives with no pop, the byte is discarded, the fill count stays 16, and the overrun flag is set on the newest stored entry.
- R6: When a byte arrives in the same cycle as a pop while the queue is full, the pop is applied first. The byte is stored, the fill count stays 16 and no overrun is flagged.
- R7: When a break arrives with exactly one free slot, only one zero entry is stored, and that entry carries the overrun flag in addition to break and framing.
- R8: A pop while the queue is empty is ignored, and the fill count stays 0.
- R9: The fill count always equals the number of stored entries and never exceeds DEPTH.
- R10: A frame with stop bit 1 has framing and break clear. A frame with stop bit 0 and non-zero data has break clear. The entry flag layout is bit 11 overrun, bit 10 break, bit 9 framing, bit 8 parity, bits 7:0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is presented |
| rx_data | input | 8 | Assembled data bits of the frame |
| rx_parity_err | input | 1 | Parity check failed for this frame |
| rx_stop_bit | input | 1 | Sampled level of the first stop bit |
| rd_pop | input | 1 | Remove the oldest entry |
| head_valid | output | 1 | Queue is not empty |
| head_data | output | 8 | Data of the oldest entry |
| head_parity | output | 1 | Parity-error flag of the oldest entry |
| head_framing | output | 1 | Framing-error flag of the oldest entry |
| head_break | output | 1 | Break flag of the oldest entry |
| head_overrun | output | 1 | Overrun flag of the oldest entry |
| fill_count | output | 5 | Number of stored entries, 0 to 16 |

## Verification
The assertions assume that `rx_valid` and `rd_pop` are clean one-cycle-per-event strobes sampled at the rising edge. They also assume that `rx_data` and `rx_stop_bit` are meaningful only while `rx_valid` is high, so every fill-count property is conditioned on these strobes. The stimulus drives every input only at the falling edge and returns the strobes to zero just after each rising edge. It may pop on an empty queue and push on a full one, because those cases lie inside the assumed input space. Random traffic mixes breaks, framing errors and pops at a rate that keeps the queue swinging between empty and full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_classify.sv
module rxq_classify
  import rxq_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] data,
  input  logic       parity_err,
  input  logic       stop_bit,
  output logic       is_framing,
  output logic       is_break,
  output logic [1:0] n_req,
  output rxq_entry_t tmpl
);
  // framing: first stop bit sampled low
  assign is_framing = valid && !stop_bit;
  // break: framing with an all-zero data field
  assign is_break   = is_framing && (data == 8'h00);
  assign n_req      = !valid ? 2'd0 : (is_break ? 2'd2 : 2'd1);

  always_comb begin
    tmpl      = '0;
    tmpl.data = is_break ? 8'h00 : data;
    tmpl.par  = parity_err;
    tmpl.frm  = is_framing;
    tmpl.brk  = is_break;
    tmpl.ovr  = 1'b0;
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    n_req,
  input  logic          pop_req,
  output logic [AW-1:0] head_idx,
  output logic [AW-1:0] wr0_idx,
  output logic [AW-1:0] wr1_idx,
  output logic [AW-1:0] last_idx,
  output logic          wr0_en,
  output logic          wr1_en,
  output logic          ovr_on_new,
  output logic          ovr_on_old,
  output logic          ev_pop,
  output logic [CW-1:0] count
);
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] free_w;
  logic [1:0]    n_acc;
  logic          ev_overrun;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p, input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  function automatic logic [AW-1:0] ptr_back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  // slots available once the pop of this cycle is applied
  function automatic logic [CW-1:0] slots_free(input logic [CW-1:0] c, input logic pop);
    return CW'(DEPTH) - c + CW'(pop);
  endfunction

  function automatic logic [1:0] accept_n(input logic [1:0] req, input logic [CW-1:0] fr);
    return (CW'(req) > fr) ? fr[1:0] : req;
  endfunction

  assign ev_pop     = pop_req && (count_q != '0);
  assign free_w     = slots_free(count_q, ev_pop);
  assign n_acc      = accept_n(n_req, free_w);
  assign ev_overrun = (CW'(n_req) > free_w);

  assign wr0_en     = (n_acc != 2'd0);
  assign wr1_en     = (n_acc == 2'd2);
  assign wr0_idx    = tail_q;
  assign wr1_idx    = ptr_step(tail_q, 1);
  assign last_idx   = ptr_back(tail_q);
  assign ovr_on_new = ev_overrun && (n_acc != 2'd0);
  assign ovr_on_old = ev_overrun && (n_acc == 2'd0);
  assign head_idx   = head_q;
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (ev_pop) head_q <= ptr_step(head_q, 1);
      tail_q  <= ptr_step(tail_q, int'(n_acc));
      count_q <= count_q + CW'(n_acc) - CW'(ev_pop);
    end
  end

  // R9: the count never passes the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R5: a full queue without pop does not grow or shrink
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && !pop_req) |=> count_q == CW'(DEPTH));
  // R8: an empty queue ignores a pop
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && pop_req && n_req == 2'd0) |=> count_q == '0);
  // R2: head pointer moves only on a pop
  a_r2_head_moves_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_pop |=> $stable(head_q));
  // R5: an overrun with no room marks an already stored entry, so the queue was not empty
  a_r5_old_mark_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_on_old |-> count_q != '0);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0_en,
  input  logic [AW-1:0] wr0_idx,
  input  rxq_entry_t    wr0_entry,
  input  logic          wr1_en,
  input  logic [AW-1:0] wr1_idx,
  input  rxq_entry_t    wr1_entry,
  input  logic          mark_en,
  input  logic [AW-1:0] mark_idx,
  input  logic [AW-1:0] rd_idx,
  output rxq_entry_t    rd_entry
);
  rxq_entry_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (wr0_en && wr0_idx == AW'(i)) begin
        mem[i] <= wr0_entry;
      end else if (wr1_en && wr1_idx == AW'(i)) begin
        mem[i] <= wr1_entry;
      end else if (mark_en && mark_idx == AW'(i)) begin
        mem[i].ovr <= 1'b1;
      end
    end
  end

  assign rd_entry = mem[rd_idx];

  // R4: the two write ports never target one slot
  a_r4_distinct_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr1_en) |-> wr0_idx != wr1_idx);
  // R5: a marked entry keeps its data and gains the overrun flag
  a_r5_mark_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !wr0_en && !wr1_en) |=> mem[$past(mark_idx)].ovr);
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_parity_err,
  input  logic          rx_stop_bit,
  input  logic          rd_pop,
  output logic          head_valid,
  output logic [7:0]    head_data,
  output logic          head_parity,
  output logic          head_framing,
  output logic          head_break,
  output logic          head_overrun,
  output logic [CW-1:0] fill_count
);
  logic          is_framing, is_break;
  logic [1:0]    n_req;
  rxq_entry_t    tmpl, e0, e1, head_e;
  logic [AW-1:0] head_idx, wr0_idx, wr1_idx, last_idx;
  logic          wr0_en, wr1_en, ovr_on_new, ovr_on_old, ev_pop;
  logic [CW-1:0] count;

  rxq_classify u_cls (
    .valid(rx_valid), .data(rx_data), .parity_err(rx_parity_err),
    .stop_bit(rx_stop_bit), .is_framing(is_framing), .is_break(is_break),
    .n_req(n_req), .tmpl(tmpl)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .n_req(n_req), .pop_req(rd_pop),
    .head_idx(head_idx), .wr0_idx(wr0_idx), .wr1_idx(wr1_idx),
    .last_idx(last_idx), .wr0_en(wr0_en), .wr1_en(wr1_en),
    .ovr_on_new(ovr_on_new), .ovr_on_old(ovr_on_old), .ev_pop(ev_pop),
    .count(count)
  );

  // the overrun lands on whichever accepted entry is newest
  always_comb begin
    e0 = tmpl;
    e1 = tmpl;
    if (ovr_on_new && !wr1_en) e0.ovr = 1'b1;
    if (ovr_on_new &&  wr1_en) e1.ovr = 1'b1;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_entry(e0),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_entry(e1),
    .mark_en(ovr_on_old), .mark_idx(last_idx),
    .rd_idx(head_idx), .rd_entry(head_e)
  );

  assign head_valid   = (count != '0);
  assign head_data    = head_e.data;
  assign head_parity  = head_e.par;
  assign head_framing = head_e.frm;
  assign head_break   = head_e.brk;
  assign head_overrun = head_e.ovr;
  assign fill_count   = count;

  // R4: a break with room for two grows the count by two
  a_r4_break_two: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && is_break && !rd_pop && fill_count <= CW'(DEPTH - 2))
    |=> fill_count == $past(fill_count) + CW'(2));
  // R2: an ordinary byte with room and no pop grows the count by one
  a_r2_byte_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !is_break && !rd_pop && fill_count < CW'(DEPTH))
    |=> fill_count == $past(fill_count) + CW'(1));
  // R6: push with pop while full keeps the queue full
  a_r6_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !is_break && rd_pop && fill_count == CW'(DEPTH))
    |=> fill_count == CW'(DEPTH));
  // R7: break with one free slot fills the queue
  a_r7_break_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && is_break && !rd_pop && fill_count == CW'(DEPTH - 1))
    |=> fill_count == CW'(DEPTH));
  // R1: nothing can be read while the queue is empty
  a_r1_pop_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> !ev_pop);
endmodule

// File: tb/rxq_status_fifo_test.sv
module rxq_status_fifo_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_parity_err = 1'b0;
  logic rx_stop_bit = 1'b1;
  logic rd_pop = 1'b0;
  logic head_valid, head_parity, head_framing, head_break, head_overrun;
  logic [7:0] head_data;
  logic [4:0] fill_count;

  int checks = 0;
  int errors = 0;
  int q[$];   // entry word: [11] ovr [10] brk [9] frm [8] par [7:0] data

  always #5 clk = ~clk;

  rxq_status_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_stop_bit(rx_stop_bit), .rd_pop(rd_pop),
    .head_valid(head_valid), .head_data(head_data), .head_parity(head_parity),
    .head_framing(head_framing), .head_break(head_break),
    .head_overrun(head_overrun), .fill_count(fill_count)
  );

  function automatic int head_word();
    return {20'd0, head_overrun, head_break, head_framing, head_parity, head_data};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk("R9 fill", int'(fill_count), q.size());
    chk("R2 head_valid", int'(head_valid), (q.size() > 0) ? 1 : 0);
    if (q.size() > 0) chk("R2 head entry", head_word(), q[0]);
  endtask

  task automatic model_update(input bit v, input int d, input bit p, input bit s, input bit pop);
    int n, w;
    bit brk;
    if (pop && q.size() > 0) void'(q.pop_front());
    if (!v) return;
    brk = !s && (d == 0);
    n = brk ? 2 : 1;
    w = (brk ? 'h400 : 0) | (!s ? 'h200 : 0) | (p ? 'h100 : 0) | (d & 'hff);
    for (int k = 0; k < n; k++) begin
      if (q.size() < DEPTH) q.push_back(w);
      else if (q.size() > 0) q[q.size() - 1] = q[q.size() - 1] | 'h800;
    end
  endtask

  task automatic step(input bit v, input int d, input bit p, input bit s, input bit pop);
    @(negedge clk);
    compare_model();
    rx_valid = v; rx_data = d[7:0]; rx_parity_err = p; rx_stop_bit = s; rd_pop = pop;
    @(posedge clk);
    model_update(v, d, p, s, pop);
    #1;
    rx_valid = 1'b0; rd_pop = 1'b0; rx_stop_bit = 1'b1; rx_parity_err = 1'b0;
    #1;
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 0, 0, 1, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk("R1 fill after reset", int'(fill_count), 0);
    chk("R1 head_valid after reset", int'(head_valid), 0);

    // R2, R3, R10: ordinary, parity and framing frames
    step(1, 'hA5, 0, 1, 0);
    step(1, 'h3C, 1, 1, 0);
    step(1, 'h81, 0, 0, 0);
    chk("R10 clean byte flags", head_word(), 'h0A5);
    step(0, 0, 0, 1, 1);
    chk("R2 parity byte", head_word(), 'h13C);
    step(0, 0, 0, 1, 1);
    chk("R3 framing byte without break", head_word(), 'h281);
    step(0, 0, 0, 1, 1);
    chk("R2 empty after pops", int'(head_valid), 0);

    // R8: pop on empty
    step(0, 0, 0, 1, 1);
    chk("R8 pop on empty", int'(fill_count), 0);

    // R4: break stores two zero entries
    step(1, 'h00, 1, 0, 0);
    chk("R4 break count", int'(fill_count), 2);
    chk("R4 break entry one", head_word(), 'h700);
    step(0, 0, 0, 1, 1);
    chk("R4 break entry two", head_word(), 'h700);
    step(0, 0, 0, 1, 1);

    // R6 then R5
    for (int i = 0; i < DEPTH; i++) step(1, 'h10 + i, 0, 1, 0);
    chk("R9 full count", int'(fill_count), 16);
    step(1, 'h77, 0, 1, 1);
    chk("R6 full swap count", int'(fill_count), 16);
    chk("R6 new head after swap", head_word(), 'h011);
    step(1, 'hEE, 0, 1, 0);
    chk("R5 overrun count", int'(fill_count), 16);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 1);
    chk("R5 overrun marks newest", head_word(), 'h877);
    step(0, 0, 0, 1, 1);

    // R7: break with one free slot
    for (int i = 0; i < DEPTH - 1; i++) step(1, 'h40 + i, 0, 1, 0);
    step(1, 'h00, 0, 0, 0);
    chk("R7 break one slot count", int'(fill_count), 16);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 1);
    chk("R7 single zero with overrun", head_word(), 'hE00);
    drain();

    // mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 60, (r < 8) ? 0 : int'($urandom_range(0, 255)),
           $urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0,
           $urandom_range(0, 99) < 45);
    end
    drain();
    step(0, 0, 0, 1, 0);
    chk("R9 final empty", int'(fill_count), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule